// File: doc/BRIEF.md
# Triggered Single-Frame Camera Capture

This block connects a free-running image sensor to frame memory. The sensor is the timing master. It drives a pixel clock, a vertical sync, a line-valid strobe and an 8-bit pixel bus, and it streams frames without pause. The block cannot ask for a frame. Software raises a capture request, and the block then waits for the next clean progressive frame boundary. It writes exactly one complete frame into memory as a stream of byte writes with linear addresses, and then goes back to idle.

Two frame-sized buffer regions are used in turn. This lets one frame be acquired while the frame captured before it is still being processed. Each completed capture is announced by a one-cycle done pulse that carries the index of the buffer just filled. A sticky flag reports lines whose length differs from the configured frame width. The whole block runs in the pixel clock domain. The asynchronous capture request is brought into that domain by a two-flop synchroniser.

Top module: `cam_frame_capture`

## Requirements
- R1: While not armed, sensor traffic has no effect: no writes, no done pulse, busy stays low.
- R2: Once armed, nothing is written until VSYNC falls. The first HREF rise after that fall starts line 0.
- R3: A request that arrives in the middle of a frame drops that frame entirely. The next whole frame is the one captured.
- R4: Each byte on `pix_in` sampled at a rising `pclk` while HREF is high is written once, with `wr_data` equal to that byte, one cycle after it was sampled.
- R5: The write address is base + line*WIDTH + pixel, where base = buffer*WIDTH*HEIGHT. The pixel index restarts at 0 on each HREF rise, and the line index advances on each HREF fall.
- R6: Captures go to buffer 0 first after reset, then alternate 1, 0, 1, and so on.
- R7: A capture ends at the HEIGHT-th HREF fall, or at the next VSYNC fall if that comes first. At that point `frame_done` is high for exactly one cycle and `done_buf` gives the buffer just filled.
- R8: A rising edge on `start_req` arms the block within three `pclk` cycles. `busy` is high from arming until the cycle in which `frame_done` is high, and it is low in that cycle.
- R9: A line whose pixel count is not WIDTH sets `line_err`. The flag holds until the next arming clears it.
- R10: In a line longer than WIDTH, the pixels past WIDTH are not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Sensor pixel clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to pclk |
| start_req | input | 1 | Asynchronous capture request; a rising edge arms the block |
| vsync | input | 1 | Sensor vertical sync; a falling edge marks frame start |
| href | input | 1 | Sensor line-valid strobe |
| pix_in | input | PIX_BITS | Sensor pixel byte |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Linear write address across both buffers |
| wr_data | output | PIX_BITS | Byte to write |
| busy | output | 1 | High from arming until frame completion |
| frame_done | output | 1 | One-cycle pulse when a capture completes |
| done_buf | output | 1 | Buffer index of the completed capture |
| line_err | output | 1 | Sticky flag for a line length mismatch |

## Verification
The assertions assume that VSYNC, HREF and the pixel bus come from the sensor and change only between pixel clock edges. They also assume that HREF is low whenever VSYNC changes, and that the capture request stays high long enough for the synchroniser to see it. The stimulus drives every input on the falling clock edge. It holds each request for four cycles and places VSYNC pulses only in line blanking. Random blanking lengths and pixel contents vary the timing within those limits.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_FRAME = 2'd2
    } cap_state_e;
endpackage

// File: rtl/cap_req_sync.sv
module cap_req_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic req_rise
);
    logic meta_q, meta_d;
    logic sync_q, sync_d;
    logic last_q, last_d;

    always_comb begin
        meta_d = req_async;
        sync_d = meta_q;
        last_d = sync_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    assign req_rise = sync_q & ~last_q;
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q, prev_d;

    always_comb prev_d = sig_in;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign rise[g] =  sig_in[g] & ~prev_q[g];
        assign fall[g] = ~sig_in[g] &  prev_q[g];
    end
endmodule

// File: rtl/cap_addr_gen.sv
module cap_addr_gen #(
    parameter int WIDTH  = 352,
    parameter int HEIGHT = 288,
    parameter int LINE_W = 9,
    parameter int PIX_W  = 9,
    parameter int ADDR_W = 18
) (
    input  logic              buf_sel,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [PIX_W-1:0]  pix_idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int FRAME_PIX = WIDTH * HEIGHT;

    always_comb begin
        addr = (buf_sel ? ADDR_W'(FRAME_PIX) : '0)
             + ADDR_W'(line_idx) * ADDR_W'(WIDTH)
             + ADDR_W'(pix_idx);
    end
endmodule

// File: rtl/cam_frame_capture.sv
module cam_frame_capture #(
    parameter int WIDTH    = 352,
    parameter int HEIGHT   = 288,
    parameter int PIX_BITS = 8,
    localparam int ADDR_W  = $clog2(2 * WIDTH * HEIGHT)
) (
    input  logic                pclk,
    input  logic                rst_n,
    input  logic                start_req,
    input  logic                vsync,
    input  logic                href,
    input  logic [PIX_BITS-1:0] pix_in,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [PIX_BITS-1:0] wr_data,
    output logic                busy,
    output logic                frame_done,
    output logic                done_buf,
    output logic                line_err
);
    import cap_pkg::*;

    localparam int PIX_W   = $clog2(WIDTH + 2);
    localparam int LINE_W  = $clog2(HEIGHT + 1);
    localparam int N_EDGE  = 2;
    localparam int IDX_VS  = 0;
    localparam int IDX_HR  = 1;

    typedef struct packed {
        cap_state_e          st;
        logic [PIX_W-1:0]    pix;
        logic [LINE_W-1:0]   line;
        logic                bufsel;
        logic                busy;
        logic                err;
        logic                done;
        logic                done_buf;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [PIX_BITS-1:0] data;
    } regs_t;

    regs_t r_q, r_d;

    logic              arm_rise;
    logic [N_EDGE-1:0] edge_in, edge_rise, edge_fall;
    logic              vs_fall, hr_rise, hr_fall;
    logic [PIX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] cur_addr;
    logic              finish;

    cap_req_sync u_sync (
        .clk       (pclk),
        .rst_n     (rst_n),
        .req_async (start_req),
        .req_rise  (arm_rise)
    );

    assign edge_in[IDX_VS] = vsync;
    assign edge_in[IDX_HR] = href;

    cap_edge_det #(.N(N_EDGE)) u_edges (
        .clk    (pclk),
        .rst_n  (rst_n),
        .sig_in (edge_in),
        .rise   (edge_rise),
        .fall   (edge_fall)
    );

    assign vs_fall = edge_fall[IDX_VS];
    assign hr_rise = edge_rise[IDX_HR];
    assign hr_fall = edge_fall[IDX_HR];
    assign cur_idx = hr_rise ? '0 : r_q.pix;

    cap_addr_gen #(
        .WIDTH  (WIDTH),
        .HEIGHT (HEIGHT),
        .LINE_W (LINE_W),
        .PIX_W  (PIX_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .buf_sel  (r_q.bufsel),
        .line_idx (r_q.line),
        .pix_idx  (cur_idx),
        .addr     (cur_addr)
    );

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        r_d.done = 1'b0;
        finish = 1'b0;
        unique case (r_q.st)
            CAP_IDLE: begin
                if (arm_rise) begin
                    r_d.st   = CAP_ARMED;
                    r_d.busy = 1'b1;
                    r_d.err  = 1'b0;
                end
            end
            CAP_ARMED: begin
                if (vs_fall) begin
                    r_d.st   = CAP_FRAME;
                    r_d.line = '0;
                    r_d.pix  = '0;
                end
            end
            CAP_FRAME: begin
                if (href) begin
                    if (cur_idx < PIX_W'(WIDTH)) begin
                        r_d.we   = 1'b1;
                        r_d.addr = cur_addr;
                        r_d.data = pix_in;
                    end
                    r_d.pix = (cur_idx == PIX_W'(WIDTH + 1)) ? cur_idx
                                                             : cur_idx + 1'b1;
                end
                if (hr_fall) begin
                    if (r_q.pix != PIX_W'(WIDTH)) r_d.err = 1'b1;
                    r_d.line = r_q.line + 1'b1;
                    if (r_q.line == LINE_W'(HEIGHT - 1)) finish = 1'b1;
                end
                if (vs_fall) finish = 1'b1;
                if (finish) begin
                    r_d.we       = 1'b0;
                    r_d.done     = 1'b1;
                    r_d.done_buf = r_q.bufsel;
                    r_d.bufsel   = ~r_q.bufsel;
                    r_d.busy     = 1'b0;
                    r_d.st       = CAP_IDLE;
                end
            end
            default: r_d.st = CAP_IDLE;
        endcase
    end

    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= CAP_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en      = r_q.we;
    assign wr_addr    = r_q.addr;
    assign wr_data    = r_q.data;
    assign busy       = r_q.busy;
    assign frame_done = r_q.done;
    assign done_buf   = r_q.done_buf;
    assign line_err   = r_q.err;
endmodule

// File: rtl/cap_frame_checker.sv
module cap_frame_checker #(
    parameter int ADDR_W     = 18,
    parameter int ADDR_LIMIT = 202752
) (
    input logic              pclk,
    input logic              rst_n,
    input logic              busy,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              frame_done,
    input logic              done_buf,
    input logic              line_err
);
    logic seen_q, last_q;

    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= 1'b0;
        end else if (frame_done) begin
            seen_q <= 1'b1;
            last_q <= done_buf;
        end
    end

    p_no_write_idle_r1: assert property (@(posedge pclk) disable iff (!rst_n)
        wr_en |-> busy);

    p_addr_bound_r5: assert property (@(posedge pclk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr) < ADDR_LIMIT));

    p_buf_alternate_r6: assert property (@(posedge pclk) disable iff (!rst_n)
        (frame_done && seen_q) |-> (done_buf != last_q));

    p_first_buf_r6: assert property (@(posedge pclk) disable iff (!rst_n)
        (frame_done && !seen_q) |-> !done_buf);

    p_done_pulse_r7: assert property (@(posedge pclk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_no_write_at_done_r7: assert property (@(posedge pclk) disable iff (!rst_n)
        frame_done |-> !wr_en);

    p_busy_end_r8: assert property (@(posedge pclk) disable iff (!rst_n)
        frame_done |-> (!busy && $past(busy)));

    p_err_clear_r9: assert property (@(posedge pclk) disable iff (!rst_n)
        $rose(busy) |-> !line_err);
endmodule

bind cam_frame_capture cap_frame_checker #(
    .ADDR_W     (ADDR_W),
    .ADDR_LIMIT (2 * WIDTH * HEIGHT)
) u_chk (
    .pclk       (pclk),
    .rst_n      (rst_n),
    .busy       (busy),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .frame_done (frame_done),
    .done_buf   (done_buf),
    .line_err   (line_err)
);

// File: tb/tb_cam_frame_capture.sv
module tb_cam_frame_capture;
    localparam int W      = 16;
    localparam int H      = 6;
    localparam int MEMN   = 2 * W * H;
    localparam int ADDR_W = $clog2(MEMN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic vsync = 1'b0;
    logic href = 1'b0;
    logic [7:0] pix_in = '0;
    logic wr_en, busy, frame_done, done_buf, line_err;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0] wr_data;

    always #2.5 clk = ~clk;

    cam_frame_capture #(.WIDTH(W), .HEIGHT(H), .PIX_BITS(8)) dut (
        .pclk(clk), .rst_n(rst_n), .start_req(start_req), .vsync(vsync),
        .href(href), .pix_in(pix_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .frame_done(frame_done),
        .done_buf(done_buf), .line_err(line_err)
    );

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    int last_buf = -1;
    logic [7:0] mem [MEMN];
    logic [7:0] salt [16];

    function automatic logic [7:0] pat(int fid, int l, int p);
        return 8'(fid * 37 + l * 11 + p * 3) ^ salt[fid & 15];
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (int'(wr_addr) < MEMN) mem[wr_addr] = wr_data;
            wr_cnt++;
        end
        if (rst_n && frame_done) begin
            done_cnt++;
            last_buf = int'(done_buf);
        end
    end

    task automatic clear_obs();
        for (int i = 0; i < MEMN; i++) mem[i] = 8'h00;
        wr_cnt = 0;
        done_cnt = 0;
    endtask

    task automatic arm();
        @(negedge clk) start_req = 1'b1;
        repeat (4) @(negedge clk);
        start_req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(int fid, int nlines, int bad_line, int bad_len, int hgap);
        @(negedge clk) vsync = 1'b1;
        repeat (3) @(negedge clk);
        vsync = 1'b0;
        repeat (3) @(negedge clk);
        for (int l = 0; l < nlines; l++) begin
            int len = (l == bad_line) ? bad_len : W;
            for (int p = 0; p < len; p++) begin
                href = 1'b1;
                pix_in = pat(fid, l, p);
                @(negedge clk);
            end
            href = 1'b0;
            pix_in = 8'h00;
            repeat (hgap) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic int mismatches(int fid, int b, int nlines, int bad_line, int bad_len);
        int m = 0;
        for (int l = 0; l < nlines; l++) begin
            int len = (l == bad_line) ? ((bad_len < W) ? bad_len : W) : W;
            for (int p = 0; p < len; p++)
                if (mem[b * W * H + l * W + p] !== pat(fid, l, p)) m++;
        end
        return m;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int mm;
        int exp_buf;
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) salt[i] = 8'($urandom);
        clear_obs();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(busy == 1'b0, "R8", "busy after reset", busy, 0);
        chk(wr_en == 1'b0, "R1", "wr_en after reset", wr_en, 0);
        chk(frame_done == 1'b0, "R7", "frame_done after reset", frame_done, 0);
        chk(line_err == 1'b0, "R9", "line_err after reset", line_err, 0);

        // R1: traffic without a request
        send_frame(1, H, -1, 0, 4);
        chk(wr_cnt == 0, "R1", "writes while idle", wr_cnt, 0);
        chk(done_cnt == 0, "R1", "done while idle", done_cnt, 0);

        // R2 R4 R5 R6: armed before a frame
        clear_obs();
        arm();
        chk(busy == 1'b1, "R8", "busy after arming", busy, 1);
        repeat (10) @(negedge clk);
        chk(wr_cnt == 0, "R2", "writes before vsync fall", wr_cnt, 0);
        send_frame(2, H, -1, 0, 4);
        chk(done_cnt == 1, "R7", "done count full frame", done_cnt, 1);
        chk(last_buf == 0, "R6", "first buffer", last_buf, 0);
        chk(wr_cnt == W * H, "R4", "write count full frame", wr_cnt, W * H);
        mm = mismatches(2, 0, H, -1, 0);
        chk(mm == 0, "R5", "buffer 0 contents", mm, 0);
        chk(busy == 1'b0, "R8", "busy after done", busy, 0);

        // R3: request in the middle of a frame
        clear_obs();
        fork
            send_frame(3, H, -1, 0, 4);
            begin
                repeat (40) @(negedge clk);
                arm();
            end
        join
        chk(wr_cnt == 0, "R3", "writes from partial frame", wr_cnt, 0);
        send_frame(4, H, -1, 0, 4);
        chk(done_cnt == 1, "R3", "done count after discard", done_cnt, 1);
        chk(last_buf == 1, "R6", "second buffer", last_buf, 1);
        chk(wr_cnt == W * H, "R3", "write count next frame", wr_cnt, W * H);
        mm = mismatches(4, 1, H, -1, 0);
        chk(mm == 0, "R3", "buffer 1 contents", mm, 0);

        // R7: short frame ended by next vsync fall
        clear_obs();
        arm();
        send_frame(5, 3, -1, 0, 4);
        chk(done_cnt == 0, "R7", "no done before vsync", done_cnt, 0);
        send_frame(6, H, -1, 0, 4);
        chk(done_cnt == 1, "R7", "done on vsync fall", done_cnt, 1);
        chk(wr_cnt == 3 * W, "R7", "short frame writes", wr_cnt, 3 * W);
        chk(last_buf == 0, "R6", "third buffer", last_buf, 0);
        mm = mismatches(5, 0, 3, -1, 0);
        chk(mm == 0, "R7", "short frame contents", mm, 0);

        // R9: short line sets sticky error
        clear_obs();
        arm();
        send_frame(7, H, 2, W - 3, 4);
        chk(line_err == 1'b1, "R9", "error after short line", line_err, 1);
        chk(wr_cnt == W * H - 3, "R9", "writes with short line", wr_cnt, W * H - 3);
        mm = mismatches(7, 1, H, 2, W - 3);
        chk(mm == 0, "R5", "contents with short line", mm, 0);
        repeat (20) @(negedge clk);
        chk(line_err == 1'b1, "R9", "error held", line_err, 1);
        clear_obs();
        arm();
        chk(line_err == 1'b0, "R9", "error cleared by arming", line_err, 0);

        // R10: long line, excess pixels dropped
        send_frame(8, H, 1, W + 2, 4);
        chk(wr_cnt == W * H, "R10", "writes with long line", wr_cnt, W * H);
        chk(line_err == 1'b1, "R9", "error after long line", line_err, 1);
        mm = mismatches(8, 0, H, 1, W + 2);
        chk(mm == 0, "R10", "contents with long line", mm, 0);

        // random frames (R4 R5 R6)
        exp_buf = 1;
        for (int k = 0; k < 6; k++) begin
            int gap = int'($urandom_range(1, 6));
            int pre = int'($urandom_range(0, 12));
            clear_obs();
            repeat (pre) @(negedge clk);
            arm();
            send_frame(9 + k, H, -1, 0, gap);
            chk(last_buf == exp_buf, "R6", "random buffer", last_buf, exp_buf);
            chk(wr_cnt == W * H, "R4", "random write count", wr_cnt, W * H);
            mm = mismatches(9 + k, exp_buf, H, -1, 0);
            chk(mm == 0, "R5", "random contents", mm, 0);
            chk(line_err == 1'b0, "R9", "no error on clean frame", line_err, 0);
            exp_buf = 1 - exp_buf;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule